// File: doc/BRIEF.md
# One-Entry Searchable Pipeline Queue

A single-slot queue meant to sit between two stages of a processor pipeline. The producing stage offers an entry with a valid/ready handshake. The consuming stage sees the stored entry on its output. It removes the entry by asserting a take strobe, and a flush input empties the slot. Each entry carries a payload, a destination-valid bit and a destination register tag.

A combinational lookup port lets an earlier stage ask whether the entry in flight writes a given register. It returns a hit flag and the payload of the matching entry, which the earlier stage uses for operand bypassing. The same-cycle view of the lookup is set by a parameter. In both settings the lookup ignores an entry that is being taken out in this cycle. In `ORD_DEQ_ENQ` it also sees an entry that is being written in this cycle. In `ORD_DEQ_ONLY` it does not see the incoming entry. A full slot accepts a new entry in the same cycle as its old entry is taken, so back-to-back traffic runs at full rate.

Top module: `sfq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot is empty after that edge: `out_valid`=0 and `in_ready`=1.
- R2: An accepted entry (`in_valid`=1, `in_ready`=1, `flush`=0) appears on `out_valid`/`out_data`/`out_dst_vld`/`out_dst_tag` in the next cycle.
- R3: When the slot is full and `out_take`=0, `in_ready` is 0. `in_valid` then has no effect: the stored entry is unchanged in the next cycle.
- R4: When the slot is full and `out_take`=1, `in_ready` is 1 and an offered entry replaces the old entry in the next cycle.
- R5: Taking a full slot without a new entry leaves the slot empty in the next cycle.
- R6: `out_take` while the slot is empty has no effect: the slot stays empty and an offered entry is still accepted.
- R7: `flush` empties the slot in the next cycle. It overrides a simultaneous accepted entry.
- R8: `find_hit`=1 only for a visible entry whose destination-valid bit is 1 and whose tag equals `find_tag`. `find_data` is that entry's payload on a hit and 0 on a miss.
- R9: An entry that is being taken (`out_take`=1 while full) is never visible to the lookup in that cycle.
- R10: With `ORDER`=`ORD_DEQ_ENQ`, an entry that is being accepted in this cycle is visible to the lookup in that cycle.
- R11: With `ORDER`=`ORD_DEQ_ONLY`, an entry that is being accepted in this cycle is not visible to the lookup in that cycle.
- R12: `flush` does not change the lookup result of its own cycle. The flush takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers an entry |
| in_ready | output | 1 | Slot can take the offered entry this cycle |
| in_data | input | DATA_W | Offered payload |
| in_dst_vld | input | 1 | Offered entry writes a register |
| in_dst_tag | input | TAG_W | Register written by the offered entry |
| out_valid | output | 1 | Slot holds an entry |
| out_data | output | DATA_W | Stored payload |
| out_dst_vld | output | 1 | Stored destination-valid bit |
| out_dst_tag | output | TAG_W | Stored destination tag |
| out_take | input | 1 | Consumer removes the stored entry |
| flush | input | 1 | Empty the slot at the next edge |
| find_tag | input | TAG_W | Register tag to look up |
| find_hit | output | 1 | Visible entry writes `find_tag` |
| find_data | output | DATA_W | Payload of the hit, else 0 |

## Verification
A wrong full flag shows in the same cycle as a wrong `in_ready` or `out_valid`. A stale or corrupted stored entry shows one cycle after the edge that wrote it, on `out_data` or on a lookup that names its tag. A wrong same-cycle ordering shows at once on `find_hit` in cycles that accept or take an entry. Because of this, the two orderings are compared side by side in every cycle. The two instances get the same mix of full/empty, take, offer and flush, so each of those cycle kinds occurs under both orderings.

// File: rtl/sfq_pkg.sv
// Shared types for the one-entry searchable queue.
package sfq_pkg;
    // Same-cycle view of the lookup port.
    typedef enum logic {
        ORD_DEQ_ONLY = 1'b0,  // sees the take, not the incoming entry
        ORD_DEQ_ENQ  = 1'b1   // sees the take and the incoming entry
    } find_order_e;
endpackage

// File: rtl/sfq_ctrl.sv
// Handshake control for a single slot.
// Assumes: full reflects the registered state; take on an empty slot is dropped.
module sfq_ctrl (
    input  logic full,
    input  logic in_valid,
    input  logic out_take,
    output logic in_ready,
    output logic enq_fire,
    output logic deq_fire
);
    // Take is effective only on a full slot; a taken slot frees room at once.
    always_comb begin
        deq_fire = full & out_take;
        in_ready = ~full | deq_fire;
        enq_fire = in_valid & in_ready;
    end
endmodule

// File: rtl/sfq_slot.sv
// Storage for one entry and its occupancy flag.
// Assumes: enq_fire is only asserted when room exists; flush wins over all.
module sfq_slot #(
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_fire,
    input  logic             deq_fire,
    input  logic             flush,
    input  logic [ENT_W-1:0] in_ent,
    output logic             full,
    output logic [ENT_W-1:0] ent
);
    // Occupancy update: reset/flush empty, write fills, take empties.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            full <= 1'b0;
        end else if (enq_fire) begin
            full <= 1'b1;
        end else if (deq_fire) begin
            full <= 1'b0;
        end
    end

    // Entry capture on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent <= '0;
        end else if (enq_fire && !flush) begin
            ent <= in_ent;
        end
    end
endmodule

// File: rtl/sfq_search.sv
// Lookup over the stored and incoming entries under a fixed same-cycle order.
// Assumes: entries are packed as {dst_vld, dst_tag, data}.
module sfq_search
    import sfq_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter int          TAG_W  = 5,
    parameter find_order_e ORDER  = ORD_DEQ_ENQ,
    localparam int         ENT_W  = DATA_W + TAG_W + 1
) (
    input  logic              full,
    input  logic              deq_fire,
    input  logic              enq_fire,
    input  logic [ENT_W-1:0]  ent,
    input  logic [ENT_W-1:0]  in_ent,
    input  logic [TAG_W-1:0]  find_tag,
    output logic              find_hit,
    output logic [DATA_W-1:0] find_data
);
    logic             cand_vld;
    logic [ENT_W-1:0] cand;

    // Pick the entry visible to the lookup for the chosen order.
    generate
        if (ORDER == ORD_DEQ_ENQ) begin : g_sees_enq
            always_comb begin
                cand_vld = enq_fire | (full & ~deq_fire);
                cand     = enq_fire ? in_ent : ent;
            end
        end else begin : g_hides_enq
            always_comb begin
                cand_vld = full & ~deq_fire;
                cand     = ent;
            end
        end
    endgenerate

    // Tag compare against the visible entry.
    always_comb begin
        find_hit  = cand_vld & cand[ENT_W-1]
                  & (cand[DATA_W +: TAG_W] == find_tag);
        find_data = find_hit ? cand[DATA_W-1:0] : '0;
    end
endmodule

// File: rtl/sfq_top.sv
// One-entry pipeline queue with a register-tag lookup port.
// Assumes: synchronous active-low reset; flush applies at the edge.
module sfq_top
    import sfq_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter int          TAG_W  = 5,
    parameter find_order_e ORDER  = ORD_DEQ_ENQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_dst_vld,
    input  logic [TAG_W-1:0]  in_dst_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_dst_vld,
    output logic [TAG_W-1:0]  out_dst_tag,
    input  logic              out_take,
    input  logic              flush,
    input  logic [TAG_W-1:0]  find_tag,
    output logic              find_hit,
    output logic [DATA_W-1:0] find_data
);
    localparam int ENT_W = DATA_W + TAG_W + 1;

    logic             full, enq_fire, deq_fire;
    logic [ENT_W-1:0] ent, in_ent;

    // Pack the offered entry.
    always_comb in_ent = {in_dst_vld, in_dst_tag, in_data};

    sfq_ctrl u_ctrl (
        .full(full), .in_valid(in_valid), .out_take(out_take),
        .in_ready(in_ready), .enq_fire(enq_fire), .deq_fire(deq_fire)
    );

    sfq_slot #(.ENT_W(ENT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .enq_fire(enq_fire), .deq_fire(deq_fire),
        .flush(flush), .in_ent(in_ent), .full(full), .ent(ent)
    );

    sfq_search #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ORDER(ORDER)) u_search (
        .full(full), .deq_fire(deq_fire), .enq_fire(enq_fire), .ent(ent),
        .in_ent(in_ent), .find_tag(find_tag), .find_hit(find_hit),
        .find_data(find_data)
    );

    // Unpack the stored entry onto the consumer side.
    always_comb begin
        out_valid   = full;
        out_dst_vld = ent[ENT_W-1];
        out_dst_tag = ent[DATA_W +: TAG_W];
        out_data    = ent[DATA_W-1:0];
    end
endmodule

// File: rtl/sfq_chk.sv
// Port-level properties of sfq_top; attached by bind below.
module sfq_chk
    import sfq_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter int          TAG_W  = 5,
    parameter find_order_e ORDER  = ORD_DEQ_ENQ
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_dst_vld,
    input logic [TAG_W-1:0]  out_dst_tag,
    input logic              out_take,
    input logic              flush,
    input logic [TAG_W-1:0]  find_tag,
    input logic              find_hit,
    input logic [DATA_W-1:0] find_data
);
    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_enq_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !flush) |=> (out_valid && out_data == $past(in_data)));

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_take) |-> !in_ready);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_take && !flush) |=> (out_valid && $stable(out_data)));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !find_hit |-> (find_data == '0));

    generate
        if (ORDER == ORD_DEQ_ONLY) begin : g_hide
            p_hit_stored_r11: assert property (@(posedge clk) disable iff (!rst_n)
                find_hit |-> (out_valid && !out_take && out_dst_vld
                              && out_dst_tag == find_tag && find_data == out_data));
        end else begin : g_see
            p_hit_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
                find_hit |-> ((in_valid && in_ready) || (out_valid && !out_take)));
        end
    endgenerate
endmodule

bind sfq_top sfq_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ORDER(ORDER)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_dst_vld(out_dst_vld), .out_dst_tag(out_dst_tag), .out_take(out_take),
    .flush(flush), .find_tag(find_tag), .find_hit(find_hit), .find_data(find_data)
);

// File: tb/sim_sfq_top.sv
module sim_sfq_top;
    import sfq_pkg::*;
    localparam int DW = 16;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_dst_vld = 1'b0, out_take = 1'b0, flush = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [TW-1:0] in_dst_tag = '0, find_tag = '0;

    logic          rdy [2], ov [2], odv [2], hit [2];
    logic [DW-1:0] od [2], fd [2];
    logic [TW-1:0] ot [2];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sfq_top #(.DATA_W(DW), .TAG_W(TW), .ORDER(ORD_DEQ_ENQ)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
        .in_data(in_data), .in_dst_vld(in_dst_vld), .in_dst_tag(in_dst_tag),
        .out_valid(ov[0]), .out_data(od[0]), .out_dst_vld(odv[0]), .out_dst_tag(ot[0]),
        .out_take(out_take), .flush(flush), .find_tag(find_tag),
        .find_hit(hit[0]), .find_data(fd[0]));

    sfq_top #(.DATA_W(DW), .TAG_W(TW), .ORDER(ORD_DEQ_ONLY)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
        .in_data(in_data), .in_dst_vld(in_dst_vld), .in_dst_tag(in_dst_tag),
        .out_valid(ov[1]), .out_data(od[1]), .out_dst_vld(odv[1]), .out_dst_tag(ot[1]),
        .out_take(out_take), .flush(flush), .find_tag(find_tag),
        .find_hit(hit[1]), .find_data(fd[1]));

    // Reference model: each instance keeps a queue of at most one entry.
    typedef struct { logic [DW-1:0] d; logic v; logic [TW-1:0] t; } ent_t;
    ent_t m_q [2][$];
    string st_tag = "R1";   // requirement that produced the current state

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare before the next posedge, advance model.
    task automatic step(input bit iv, input bit take, input bit fl,
                        input logic [DW-1:0] d, input bit dv, input logic [TW-1:0] t,
                        input logic [TW-1:0] ft);
        @(negedge clk);
        in_valid = iv; out_take = take; flush = fl; in_data = d;
        in_dst_vld = dv; in_dst_tag = t; find_tag = ft;
        #4;
        for (int k = 0; k < 2; k++) begin
            bit full = (m_q[k].size() == 1);
            bit deq  = full && take;
            bit ready = !full || deq;
            bit enq  = iv && ready;
            bit cv; ent_t c; bit eh; int ed;
            string hreq;
            ent_t ne; ne.d = d; ne.v = dv; ne.t = t;
            chk(full ? (take ? "R4" : "R3") : (take ? "R6" : "R2"), "in_ready", rdy[k], ready);
            chk(st_tag, "out_valid", ov[k], full);
            if (full) begin
                chk(st_tag, "out_data", od[k], m_q[k][0].d);
                chk(st_tag, "out_dst", {odv[k], ot[k]}, {m_q[k][0].v, m_q[k][0].t});
            end
            if (k == 0 && enq) begin cv = 1; c = ne; end
            else if (full && !deq) begin cv = 1; c = m_q[k][0]; end
            else begin cv = 0; c = ne; end
            eh = cv && c.v && (c.t == ft);
            ed = eh ? c.d : 0;
            hreq = fl ? "R12" : (enq ? (k == 0 ? "R10" : "R11") : (deq ? "R9" : "R8"));
            chk(hreq, "find_hit", hit[k], eh);
            chk(hreq, "find_data", fd[k], ed);
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            bit full = (m_q[k].size() == 1);
            bit deq  = full && take;
            bit enq  = iv && (!full || deq);
            ent_t ne; ne.d = d; ne.v = dv; ne.t = t;
            if (fl) m_q[k].delete();
            else if (enq) begin m_q[k].delete(); m_q[k].push_back(ne); end
            else if (deq) m_q[k].delete();
        end
        st_tag = fl ? "R7" : ((iv && take) ? "R4" : (take ? "R5" : (iv ? "R2" : "R3")));
        if (take && !iv && !fl && m_q[0].size() == 0) st_tag = "R6";
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #4;
        for (int k = 0; k < 2; k++) begin
            chk("R1", "out_valid after reset", ov[k], 0);
            chk("R1", "in_ready after reset", rdy[k], 1);
        end
        // R6 take on empty, then fill (R2, R10/R11 same-cycle view)
        step(0, 1, 0, 16'h0000, 0, 0, 3);
        step(1, 0, 0, 16'h1111, 1, 3, 3);
        // R3 full, offer ignored, lookup hits stored entry (R8)
        step(1, 0, 0, 16'h2222, 1, 3, 3);
        step(0, 0, 0, 16'h0000, 0, 0, 2);
        // R4 take and refill in one cycle; R9 old entry hidden
        step(1, 1, 0, 16'h3333, 1, 2, 3);
        step(1, 1, 0, 16'h4444, 1, 2, 2);
        // R8 destination-valid bit clear gives a miss
        step(1, 1, 0, 16'h5555, 0, 1, 1);
        step(0, 0, 0, 16'h0000, 0, 0, 1);
        // R5 take without refill
        step(0, 1, 0, 16'h0000, 0, 0, 1);
        // R7 flush overrides an accepted entry; R12 lookup unaffected
        step(1, 0, 1, 16'h6666, 1, 4, 4);
        step(0, 0, 0, 16'h0000, 0, 0, 4);
        step(1, 0, 0, 16'h7777, 1, 4, 4);
        step(1, 1, 1, 16'h8888, 1, 4, 4);
        step(0, 0, 0, 16'h0000, 0, 0, 4);
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 9) == 0),
                 DW'($urandom), $urandom_range(0, 3) != 0, TW'($urandom_range(0, 3)),
                 TW'($urandom_range(0, 3)));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule